// File: doc/BRIEF.md
# Dual-Mode Two-Bit Burst Sequencer

This block produces the address for each beat of a four-beat memory burst. A burst starts with a load cycle. In that cycle the whole external address is captured: the upper bits are held for the rest of the burst, and the two low bits become the starting beat. Each later advance cycle moves the two low bits one step through the burst. The order of the steps depends on a static mode input. In interleaved order each beat is the starting value XOR the step index. In linear order each step adds one modulo four.

A single strobe chooses between the two operations: low loads, high advances. A stall input freezes every output and all internal state, whatever the strobe and address inputs do. A one-cycle wrap flag marks the advance that brings the sequence back to its starting beat after four steps. The counter then keeps cycling through the same four beats; it never saturates. All outputs are registered and take their new value on the clock edge that accepts an operation.

Top module: `burst_lsb_seq`

## Requirements
- R1: While reset is high, a clock edge drives addr_out to all zeros, beat_out to 2'b00 and wrap to 0, and clears the step index.
- R2: On an edge with stall=0 and seq_adv=0 (load), addr_out takes the full value of ext_addr, the step index is cleared and wrap is 0 after that edge.
- R3: With mode_intlv=1, the k-th advance after a load sets beat_out to start XOR (k mod 4), where start is ext_addr[1:0] at the load (start 01 gives 01,00,11,10,01,...).
- R4: With mode_intlv=0, the k-th advance after a load sets beat_out to (start + k) mod 4 (start 01 gives 01,10,11,00,01,...).
- R5: On an advance edge (stall=0, seq_adv=1), addr_out[ADDR_W-1:2] keeps its loaded value and ext_addr is ignored.
- R6: On an edge with stall=1, addr_out, beat_out and wrap keep their values, whatever seq_adv and ext_addr are.
- R7: wrap is 1 after the advance edges that make the step count since the last load a non-zero multiple of four (the 4th, 8th, ... advance). After any other accepted edge wrap is 0. The sequence keeps repeating and never saturates.
- R8: A load in the middle of a burst abandons the old burst. The following advances step from the new start, and the wrap count restarts from that load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_intlv | input | 1 | Static burst order: 1 interleaved, 0 linear |
| stall | input | 1 | 1 freezes all state and outputs |
| seq_adv | input | 1 | 0 loads from ext_addr, 1 advances one beat |
| ext_addr | input | ADDR_W | External starting address |
| addr_out | output | ADDR_W | Current beat address (upper bits loaded, low two bits sequenced) |
| beat_out | output | 2 | Current two low address bits |
| wrap | output | 1 | Pulses after the advance that returns to the starting beat |

## Verification
Every result is due one edge after the cycle that presents its stimulus. A load, an advance or a stall shows up on addr_out, beat_out and wrap after that single rising edge, with no extra pipeline stage. The bench therefore drives inputs at a falling edge. It lets one rising edge pass and compares the outputs at the next falling edge against a behavioural model, which counts advances since the last load and derives the beat arithmetically. The wrap flag is compared in the same cycle as the beat that returns to the start, so an off-by-one pulse is caught at once.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

    localparam int BEAT_W = 2;

    typedef logic [BEAT_W-1:0] beat_t;

    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_LOAD = 2'd1,
        OP_STEP = 2'd2
    } seq_op_e;

    typedef struct packed {
        beat_t start;
        beat_t step;
        logic  wrap;
    } seq_state_t;

    localparam seq_state_t SEQ_IDLE = '{start: '0, step: '0, wrap: 1'b0};

    function automatic seq_op_e decode_op(input logic stall, input logic seq_adv);
        seq_op_e op;
        if (stall)
            op = OP_HOLD;
        else if (!seq_adv)
            op = OP_LOAD;
        else
            op = OP_STEP;
        return op;
    endfunction

    function automatic beat_t order_beat(input logic intlv, input beat_t start,
                                         input beat_t step);
        beat_t b;
        if (intlv)
            b = start ^ step;
        else
            b = beat_t'(start + step);
        return b;
    endfunction

endpackage

// File: rtl/burst_step_ctr.sv
module burst_step_ctr
    import burst_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  seq_op_e    op,
    input  beat_t      load_start,
    output seq_state_t state
);

    seq_state_t state_q;
    seq_state_t state_d;
    beat_t      step_inc;

    always_comb begin
        step_inc = beat_t'(state_q.step + 1'b1);
        state_d  = state_q;
        case (op)
            OP_LOAD: begin
                state_d.start = load_start;
                state_d.step  = '0;
                state_d.wrap  = 1'b0;
            end
            OP_STEP: begin
                state_d.step = step_inc;
                state_d.wrap = (step_inc == '0);
            end
            default: state_d = state_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= SEQ_IDLE;
        else
            state_q <= state_d;
    end

    assign state = state_q;

endmodule

// File: rtl/burst_upper_reg.sv
module burst_upper_reg
    import burst_seq_pkg::*;
#(
    parameter int UPPER_W = 18
) (
    input  logic               clk,
    input  logic               rst,
    input  seq_op_e            op,
    input  logic [UPPER_W-1:0] upper_in,
    output logic [UPPER_W-1:0] upper_out
);

    logic [UPPER_W-1:0] upper_q;

    always_ff @(posedge clk) begin
        if (rst)
            upper_q <= '0;
        else if (op == OP_LOAD)
            upper_q <= upper_in;
    end

    assign upper_out = upper_q;

endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
    import burst_seq_pkg::*;
(
    input  logic  mode_intlv,
    input  beat_t start,
    input  beat_t step,
    output beat_t beat
);

    assign beat = order_beat(mode_intlv, start, step);

endmodule

// File: rtl/burst_lsb_seq.sv
module burst_lsb_seq
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_intlv,
    input  logic              stall,
    input  logic              seq_adv,
    input  logic [ADDR_W-1:0] ext_addr,
    output logic [ADDR_W-1:0] addr_out,
    output logic [1:0]        beat_out,
    output logic              wrap
);

    localparam int UPPER_W = ADDR_W - BEAT_W;

    seq_op_e            op;
    seq_state_t         st;
    beat_t              beat;
    logic [UPPER_W-1:0] upper;

    assign op = decode_op(stall, seq_adv);

    burst_step_ctr ctr_i (
        .clk        (clk),
        .rst        (rst),
        .op         (op),
        .load_start (ext_addr[BEAT_W-1:0]),
        .state      (st)
    );

    burst_upper_reg #(.UPPER_W(UPPER_W)) upper_i (
        .clk       (clk),
        .rst       (rst),
        .op        (op),
        .upper_in  (ext_addr[ADDR_W-1:BEAT_W]),
        .upper_out (upper)
    );

    burst_order_map map_i (
        .mode_intlv (mode_intlv),
        .start      (st.start),
        .step       (st.step),
        .beat       (beat)
    );

    assign beat_out = beat;
    assign addr_out = {upper, beat};
    assign wrap     = st.wrap;

endmodule

// File: rtl/burst_lsb_seq_chk.sv
module burst_lsb_seq_chk #(
    parameter int ADDR_W = 20
) (
    input logic              clk,
    input logic              rst,
    input logic              mode_intlv,
    input logic              stall,
    input logic              seq_adv,
    input logic [ADDR_W-1:0] ext_addr,
    input logic [ADDR_W-1:0] addr_out,
    input logic [1:0]        beat_out,
    input logic              wrap
);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (addr_out == '0) && (beat_out == 2'b00) && !wrap);

    // R2
    load_capture_chk: assert property (@(posedge clk) disable iff (rst)
        (!stall && !seq_adv) |=> (addr_out == $past(ext_addr)) && !wrap);

    // R3
    intlv_toggle_chk: assert property (@(posedge clk) disable iff (rst)
        (!stall && seq_adv && mode_intlv) |=> (beat_out[0] != $past(beat_out[0])));

    // R4
    linear_inc_chk: assert property (@(posedge clk) disable iff (rst)
        (!stall && seq_adv && !mode_intlv) |=> (beat_out == 2'($past(beat_out) + 2'd1)));

    // R5
    upper_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (!stall && seq_adv) |=> (addr_out[ADDR_W-1:2] == $past(addr_out[ADDR_W-1:2])));

    // R6
    stall_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        stall |=> $stable(addr_out) && $stable(wrap));

    // R7
    wrap_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(wrap) |-> ($past(seq_adv) && !$past(stall)));

endmodule

bind burst_lsb_seq burst_lsb_seq_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .mode_intlv (mode_intlv),
    .stall      (stall),
    .seq_adv    (seq_adv),
    .ext_addr   (ext_addr),
    .addr_out   (addr_out),
    .beat_out   (beat_out),
    .wrap       (wrap)
);

// File: tb/burst_lsb_seq_tb_top.sv
`timescale 1ns/1ps
module burst_lsb_seq_tb_top;

    localparam int AW = 20;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          mode_intlv = 1'b1;
    logic          stall = 1'b0;
    logic          seq_adv = 1'b0;
    logic [AW-1:0] ext_addr = '0;
    logic [AW-1:0] addr_out;
    logic [1:0]    beat_out;
    logic          wrap;

    int errors = 0;
    int checks = 0;

    int m_upper = 0;
    int m_start = 0;
    int m_k     = 0;
    int m_wrap  = 0;

    always #2.5 clk = ~clk;

    burst_lsb_seq #(.ADDR_W(AW)) dut_i (
        .clk        (clk),
        .rst        (rst),
        .mode_intlv (mode_intlv),
        .stall      (stall),
        .seq_adv    (seq_adv),
        .ext_addr   (ext_addr),
        .addr_out   (addr_out),
        .beat_out   (beat_out),
        .wrap       (wrap)
    );

    function automatic int exp_beat();
        if (mode_intlv)
            return m_start ^ (m_k % 4);
        else
            return (m_start + m_k) % 4;
    endfunction

    task automatic check_int(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all(input string tag, input string utag, input string wtag);
        check_int(tag, "beat_out", int'(beat_out), exp_beat());
        check_int(tag, "addr_out low", int'(addr_out[1:0]), exp_beat());
        check_int(utag, "addr_out upper", int'(addr_out[AW-1:2]), m_upper);
        check_int(wtag, "wrap", int'(wrap), m_wrap);
    endtask

    task automatic do_reset(input logic mode);
        @(negedge clk);
        rst = 1'b1;
        mode_intlv = mode;
        stall = 1'b0;
        seq_adv = 1'b1;
        ext_addr = '1;
        @(posedge clk);
        @(negedge clk);
        m_upper = 0; m_start = 0; m_k = 0; m_wrap = 0;
        compare_all("R1", "R1", "R1");
        rst = 1'b0;
    endtask

    // Entered at a falling edge; drives, lets one rising edge pass, compares.
    task automatic cyc(input logic s, input logic adv, input logic [AW-1:0] a, input string tag);
        string utag, wtag;
        stall = s;
        seq_adv = adv;
        ext_addr = a;
        @(posedge clk);
        @(negedge clk);
        utag = tag;
        wtag = tag;
        if (!s) begin
            if (!adv) begin
                m_upper = int'(a >> 2);
                m_start = int'(a[1:0]);
                m_k = 0;
                m_wrap = 0;
            end else begin
                m_k = m_k + 1;
                m_wrap = ((m_k % 4) == 0) ? 1 : 0;
                utag = "R5";
                wtag = "R7";
            end
        end
        compare_all(tag, utag, wtag);
    endtask

    task automatic run_mode(input logic mode);
        string otag;
        otag = mode ? "R3" : "R4";
        do_reset(mode);
        for (int st = 0; st < 4; st++) begin
            cyc(1'b0, 1'b0, AW'((st * 37 + 5) << 2) | AW'(st), "R2");
            for (int k = 0; k < 9; k++) begin
                cyc(1'b0, 1'b1, AW'(k * 911 + 3), otag);
                if (k == 2) begin
                    cyc(1'b1, 1'b0, AW'(20'hABCDE), "R6");
                    cyc(1'b1, 1'b1, AW'(20'h12345), "R6");
                end
            end
        end
        // stall held while the wrap flag is high
        cyc(1'b0, 1'b0, AW'(20'h00F02), "R2");
        for (int k = 0; k < 4; k++) cyc(1'b0, 1'b1, '0, otag);
        cyc(1'b1, 1'b0, AW'(20'h55551), "R6");
        cyc(1'b0, 1'b1, '0, otag);
        // reload in the middle of a burst
        cyc(1'b0, 1'b0, AW'(20'h3C3C1), "R2");
        cyc(1'b0, 1'b1, '0, otag);
        cyc(1'b0, 1'b1, '0, otag);
        cyc(1'b0, 1'b0, AW'(20'h0A0A3), "R8");
        for (int k = 0; k < 5; k++) cyc(1'b0, 1'b1, AW'(k), "R8");
        // back-to-back loads
        cyc(1'b0, 1'b0, AW'(20'hFFFFF), "R2");
        cyc(1'b0, 1'b0, AW'(20'h00002), "R2");
        cyc(1'b0, 1'b1, '0, otag);
    endtask

    initial begin
        fork
            begin
                run_mode(1'b1);
                run_mode(1'b0);
            end
            begin
                repeat (20000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog all requirements actual=hung expected=finished");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule